// File: doc/BRIEF.md
# Register Stack Configuration Controller

This block holds the configuration register of a register-stack spill/fill engine and enforces the access rules tied to it. Software writes the register together with the caller's current privilege level. The block keeps a mode field, a privilege field, a byte-order bit and a reload count. It decodes the mode into separate eager-load and eager-store enables for the engine, and it reports the privilege level the engine uses for its memory accesses.

Three kinds of guarded control operation pass through the block: a reload request, an access to the backing-store pointer, and an access to the NaT-collection register. Each is granted only in enforced-lazy mode. In any other mode the block raises an illegal-operation fault in the same cycle and withholds the grant, so the operation has no effect. The block also decides whether a spill or fill of the NaT-collection register may proceed.

Top module: `rscc_top`

## Requirements
- R1: After reset the register reads as all zeros: enforced-lazy mode 00, privilege 0, little-endian byte order (bit 4 = 0), reload count 0.
- R2: The 2-bit mode field sits in bits [1:0] and means 00 enforced lazy, 01 store intensive, 10 load intensive, 11 eager. `eager_st_en_o` equals mode bit 0 and `eager_ld_en_o` equals mode bit 1.
- R3: On a write, the stored privilege field (bits [3:2]) is the numerical maximum of `cur_pl_i` and `cfg_wdata_i[3:2]`.
- R4: Only bits [1:0], [3:2], [4] and [29:16] are kept. Every other bit reads as zero whatever was written to it. A write takes effect on the next clock edge.
- R5: `fault_o` is high in the same cycle as any request on `guard_req_i` while the mode is non-zero, and low otherwise. The bit order is 0 reload, 1 backing-store pointer access, 2 NaT-collection register access.
- R6: `guard_grant_o` mirrors `guard_req_i` in enforced-lazy mode and is all zero while the mode is non-zero. A faulted request leaves the register contents unchanged.
- R7: `nat_xfer_ok_o` is high only for a NaT-collection spill/fill request made when the mode is non-zero (eager transfer), or made in enforced-lazy mode with `nat_mand_next_i` high (a mandatory spill/fill follows).
- R8: `eff_pl_o` equals the stored privilege field when `xlat_en_i` is high, and 0 when it is low.
- R9: The reload count is stored from `cfg_wdata_i[29:16]` and driven on `reload_cnt_o`. The byte-order bit is stored from bit 4 and driven on `byte_order_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cur_pl_i | input | 2 | Privilege level of the current caller |
| xlat_en_i | input | 1 | Address translation enabled |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register contents |
| guard_req_i | input | 3 | Guarded operation requests: reload, pointer access, NaT-collection access |
| guard_grant_o | output | 3 | Per-request grant, enforced-lazy only |
| fault_o | output | 1 | Illegal-operation fault, same cycle as the request |
| nat_xfer_req_i | input | 1 | Request to spill/fill the NaT-collection register |
| nat_mand_next_i | input | 1 | A mandatory register spill/fill follows |
| nat_xfer_ok_o | output | 1 | NaT-collection spill/fill permitted |
| eager_ld_en_o | output | 1 | Eager loads enabled |
| eager_st_en_o | output | 1 | Eager stores enabled |
| eff_pl_o | output | 2 | Privilege level for engine memory accesses |
| byte_order_o | output | 1 | Stored byte-order bit |
| reload_cnt_o | output | 14 | Stored reload count |

## Verification
The bench uses the default parameters: a 32-bit register, a 2-bit privilege field and a 14-bit reload count at bit 16. With these values the privilege field can take its maximum value 3, so the bench can clip in both directions, including a privileged write that asks for level 0 from level 3. The full count field and the reserved bits at both ends of the word are in range, so writing all ones shows which bits are kept. The bench visits all four modes and checks each guarded request in lazy mode and in a non-lazy mode.

// File: rtl/rscc_pkg.sv
package rscc_pkg;
  typedef enum logic [1:0] {
    MODE_LAZY  = 2'b00,
    MODE_STORE = 2'b01,
    MODE_LOAD  = 2'b10,
    MODE_EAGER = 2'b11
  } rse_mode_e;

  localparam int MODE_LSB = 0;
  localparam int PL_LSB   = 2;
  localparam int N_GUARD  = 3;
  localparam int G_RELOAD = 0;
  localparam int G_PTR    = 1;
  localparam int G_NAT    = 2;
endpackage

// File: rtl/rscc_cfg_reg.sv
module rscc_cfg_reg
  import rscc_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int PL_W    = 2,
  parameter int CNT_W   = 14,
  parameter int CNT_LSB = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [PL_W-1:0]  cur_pl_i,
  output logic [REG_W-1:0] rdata_o,
  output rse_mode_e        mode_o,
  output logic [PL_W-1:0]  pl_o,
  output logic             be_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int BE_BIT = PL_LSB + PL_W;
  localparam logic [REG_W-1:0] LOW_MASK = REG_W'((64'd1 << (BE_BIT + 1)) - 64'd1);
  localparam logic [REG_W-1:0] CNT_MASK = REG_W'(((64'd1 << CNT_W) - 64'd1) << CNT_LSB);
  localparam logic [REG_W-1:0] KEEP_MASK = LOW_MASK | CNT_MASK;

  logic [REG_W-1:0] reg_q, reg_d;
  logic [PL_W-1:0]  wr_pl, clip_pl;

  assign wr_pl   = wdata_i[PL_LSB +: PL_W];
  assign clip_pl = (wr_pl > cur_pl_i) ? wr_pl : cur_pl_i;

  always_comb begin
    reg_d = wdata_i & KEEP_MASK;
    reg_d[PL_LSB +: PL_W] = clip_pl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (we_i) reg_q <= reg_d;
  end

  assign rdata_o = reg_q;
  assign mode_o  = rse_mode_e'(reg_q[MODE_LSB +: 2]);
  assign pl_o    = reg_q[PL_LSB +: PL_W];
  assign be_o    = reg_q[BE_BIT];
  assign cnt_o   = reg_q[CNT_LSB +: CNT_W];

  assert_pl_clip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (pl_o >= $past(cur_pl_i)) && (pl_o >= $past(wdata_i[PL_LSB +: PL_W])));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
  assert_mode_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_o == rse_mode_e'($past(wdata_i[MODE_LSB +: 2])));
endmodule

// File: rtl/rscc_mode_dec.sv
module rscc_mode_dec
  import rscc_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  rse_mode_e       mode_i,
  input  logic [PL_W-1:0] pl_i,
  input  logic            xlat_en_i,
  input  logic            nat_req_i,
  input  logic            nat_mand_next_i,
  output logic            lazy_o,
  output logic            eager_ld_o,
  output logic            eager_st_o,
  output logic            nat_ok_o,
  output logic [PL_W-1:0] eff_pl_o
);
  always_comb begin
    eager_ld_o = 1'b0;
    eager_st_o = 1'b0;
    unique case (mode_i)
      MODE_LAZY:  ;
      MODE_STORE: eager_st_o = 1'b1;
      MODE_LOAD:  eager_ld_o = 1'b1;
      MODE_EAGER: begin eager_ld_o = 1'b1; eager_st_o = 1'b1; end
      default:    ;
    endcase
  end

  assign lazy_o   = (mode_i == MODE_LAZY);
  // lazy: NaT-collection moves only ahead of a mandatory spill/fill
  assign nat_ok_o = nat_req_i & (~lazy_o | nat_mand_next_i);
  assign eff_pl_o = xlat_en_i ? pl_i : '0;
endmodule

// File: rtl/rscc_access_chk.sv
module rscc_access_chk
  import rscc_pkg::*;
#(
  parameter int N = N_GUARD
) (
  input  logic         lazy_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         fault_o
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_guard
    assign grant_o[g] = req_i[g] & lazy_i;
    assign hit[g]     = req_i[g] & ~lazy_i;
  end

  assign fault_o = |hit;
endmodule

// File: rtl/rscc_top.sv
module rscc_top
  import rscc_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int PL_W    = 2,
  parameter int CNT_W   = 14,
  parameter int CNT_LSB = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PL_W-1:0]    cur_pl_i,
  input  logic               xlat_en_i,
  input  logic               cfg_we_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  output logic [REG_W-1:0]   cfg_rdata_o,
  input  logic [N_GUARD-1:0] guard_req_i,
  output logic [N_GUARD-1:0] guard_grant_o,
  output logic               fault_o,
  input  logic               nat_xfer_req_i,
  input  logic               nat_mand_next_i,
  output logic               nat_xfer_ok_o,
  output logic               eager_ld_en_o,
  output logic               eager_st_en_o,
  output logic [PL_W-1:0]    eff_pl_o,
  output logic               byte_order_o,
  output logic [CNT_W-1:0]   reload_cnt_o
);
  rse_mode_e       mode;
  logic [PL_W-1:0] pl;
  logic            lazy;

  rscc_cfg_reg #(
    .REG_W(REG_W), .PL_W(PL_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)
  ) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .cur_pl_i (cur_pl_i),
    .rdata_o  (cfg_rdata_o),
    .mode_o   (mode),
    .pl_o     (pl),
    .be_o     (byte_order_o),
    .cnt_o    (reload_cnt_o)
  );

  rscc_mode_dec #(.PL_W(PL_W)) u_dec (
    .mode_i          (mode),
    .pl_i            (pl),
    .xlat_en_i       (xlat_en_i),
    .nat_req_i       (nat_xfer_req_i),
    .nat_mand_next_i (nat_mand_next_i),
    .lazy_o          (lazy),
    .eager_ld_o      (eager_ld_en_o),
    .eager_st_o      (eager_st_en_o),
    .nat_ok_o        (nat_xfer_ok_o),
    .eff_pl_o        (eff_pl_o)
  );

  rscc_access_chk #(.N(N_GUARD)) u_chk (
    .lazy_i  (lazy),
    .req_i   (guard_req_i),
    .grant_o (guard_grant_o),
    .fault_o (fault_o)
  );

  assert_eager_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eager_st_en_o == cfg_rdata_o[0]) && (eager_ld_en_o == cfg_rdata_o[1]));
  assert_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|guard_req_i) && (cfg_rdata_o[1:0] != 2'b00)) |-> fault_o);
  assert_no_fault_lazy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[1:0] == 2'b00) |-> !fault_o);
  assert_no_grant_on_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (guard_grant_o == '0));
  assert_nat_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nat_xfer_ok_o |-> nat_xfer_req_i && ((cfg_rdata_o[1:0] != 2'b00) || nat_mand_next_i));
  assert_eff_pl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlat_en_i |-> (eff_pl_o == '0));
  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[15:5] == '0) && (cfg_rdata_o[31:30] == '0));
endmodule

// File: tb/tb_rscc_top.sv
module tb_rscc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cur_pl = '0;
  logic        xlat = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  req = '0;
  logic [2:0]  grant;
  logic        fault;
  logic        nat_req = 1'b0;
  logic        nat_next = 1'b0;
  logic        nat_ok;
  logic        eld, est;
  logic [1:0]  eff_pl;
  logic        be;
  logic [13:0] cnt;

  always #4 clk = ~clk;

  rscc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cur_pl_i(cur_pl), .xlat_en_i(xlat),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .guard_req_i(req), .guard_grant_o(grant), .fault_o(fault),
    .nat_xfer_req_i(nat_req), .nat_mand_next_i(nat_next), .nat_xfer_ok_o(nat_ok),
    .eager_ld_en_o(eld), .eager_st_en_o(est), .eff_pl_o(eff_pl),
    .byte_order_o(be), .reload_cnt_o(cnt)
  );

  typedef struct packed {
    logic [31:0] rdata;
    logic [2:0]  grant;
    logic        fault;
    logic        nat_ok;
    logic        eld;
    logic        est;
    logic [1:0]  eff_pl;
    logic        be;
    logic [13:0] cnt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  event  drv_ev;

  // bench model of the register
  logic [1:0]  m_mode = '0;
  logic [1:0]  m_pl = '0;
  logic        m_be = 1'b0;
  logic [13:0] m_cnt = '0;

  task automatic cmp(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [31:0] wd, input logic [1:0] cpl,
                      input logic xl, input logic [2:0] rq, input logic nr,
                      input logic nn, input string tag);
    exp_t e;
    @(negedge clk);
    we = w; wdata = wd; cur_pl = cpl; xlat = xl; req = rq; nat_req = nr; nat_next = nn;
    e.rdata  = {2'b00, m_cnt, 11'b0, m_be, m_pl, m_mode};
    e.grant  = (m_mode == 2'b00) ? rq : 3'b000;
    e.fault  = (|rq) && (m_mode != 2'b00);
    e.nat_ok = nr && ((m_mode != 2'b00) || nn);
    e.eld    = m_mode[1];
    e.est    = m_mode[0];
    e.eff_pl = xl ? m_pl : 2'b00;
    e.be     = m_be;
    e.cnt    = m_cnt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> drv_ev;
    if (w) begin
      m_mode = wd[1:0];
      m_pl   = (wd[3:2] > cpl) ? wd[3:2] : cpl;
      m_be   = wd[4];
      m_cnt  = wd[29:16];
    end
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(drv_ev);
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp({t, "/R4"}, "rdata", rdata, e.rdata);
      cmp({t, "/R6"}, "grant", {29'b0, grant}, {29'b0, e.grant});
      cmp({t, "/R5"}, "fault", {31'b0, fault}, {31'b0, e.fault});
      cmp({t, "/R7"}, "nat_ok", {31'b0, nat_ok}, {31'b0, e.nat_ok});
      cmp({t, "/R2"}, "eager", {30'b0, eld, est}, {30'b0, e.eld, e.est});
      cmp({t, "/R8"}, "eff_pl", {30'b0, eff_pl}, {30'b0, e.eff_pl});
      cmp({t, "/R9"}, "be_cnt", {17'b0, be, cnt}, {17'b0, e.be, e.cnt});
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    #10;
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, with xlat on to show pl 0
    step(0, 32'h0, 2'd0, 1, 3'b000, 0, 0, "R1");
    // R6 lazy: each guarded request granted, no fault (R5)
    step(0, 32'h0, 2'd0, 0, 3'b001, 0, 0, "R6_reload");
    step(0, 32'h0, 2'd0, 0, 3'b010, 0, 0, "R6_ptr");
    step(0, 32'h0, 2'd0, 0, 3'b100, 0, 0, "R6_nat");
    // R7 lazy NaT gate
    step(0, 32'h0, 2'd0, 0, 3'b000, 1, 0, "R7_lazy_nofollow");
    step(0, 32'h0, 2'd0, 0, 3'b000, 1, 1, "R7_lazy_follow");
    // R3/R4/R9: write all ones but pl=1, mode=01, from cur_pl 2
    step(1, 32'hFFFF_FFF5 & 32'hFFFF_FFF5, 2'd2, 1, 3'b000, 0, 0, "R3_write");
    step(0, 32'h0, 2'd0, 1, 3'b000, 0, 0, "R3_after");
    // R5 store-intensive: each guarded request faults
    step(0, 32'h0, 2'd0, 0, 3'b001, 0, 0, "R5_reload");
    step(0, 32'h0, 2'd0, 0, 3'b010, 0, 0, "R5_ptr");
    step(0, 32'h0, 2'd0, 0, 3'b100, 1, 0, "R5_nat_R7_eager");
    step(0, 32'h0, 2'd0, 0, 3'b111, 0, 0, "R6_noeffect");
    // R3 write load-intensive, pl 3 from cur 0; count pattern
    step(1, 32'h2ABC_000A | 32'h0000_000C, 2'd0, 1, 3'b000, 0, 0, "R3_up");
    step(0, 32'h0, 2'd0, 1, 3'b000, 0, 0, "R8_xlat_on");
    step(0, 32'h0, 2'd0, 0, 3'b000, 0, 0, "R8_xlat_off");
    // R2 eager mode
    step(1, 32'h0000_0003, 2'd1, 1, 3'b000, 0, 0, "R2_eager_wr");
    step(0, 32'h0, 2'd0, 1, 3'b010, 1, 0, "R2_eager");
    // R3 privileged caller at 3 asking for 0, back to lazy
    step(1, 32'h0001_0010, 2'd3, 1, 3'b000, 0, 0, "R3_clip");
    step(0, 32'h0, 2'd0, 1, 3'b011, 1, 0, "R3_lazy_back");
    step(0, 32'h0, 2'd0, 1, 3'b000, 1, 1, "R7_follow");
    // write on a cycle with a lazy request: old state visible that cycle
    step(1, 32'h0000_0001, 2'd0, 0, 3'b100, 0, 0, "R4_same_cycle");
    step(0, 32'h0, 2'd0, 0, 3'b100, 0, 0, "R5_after_wr");
    step(0, 32'h0, 2'd0, 0, 3'b000, 0, 0, "R4_final");
    @(negedge clk);
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule